// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-side register file of a simple serial port. A host reaches four word-aligned registers through a plain read/write port: receive data, transmit data, status and control. Received bytes come from a serializer over a byte-wide valid/ready input and collect in an eight-entry queue. Bytes written by the host wait in a single-entry holding buffer and leave over a byte-wide valid/ready output. Shift logic, baud timing, framing and parity checks all sit outside this block. The serializer's overrun, frame and parity indications arrive as level inputs and are only shown in the status register.

Back-pressure rules for both byte streams follow the usual valid/ready contract. A transfer happens on a clock edge where valid and ready are both high. On the receive side, `rx_ready` is high only while the queue has room. A byte offered with `rx_valid` while `rx_ready` is low is dropped, not stalled. On the transmit side, `tx_valid` and `tx_data` hold steady until `tx_ready` accepts the byte. A transmit reset or a fresh host write are the only things that can change them earlier.

A register read is answered one cycle after the request, with `bus_rvalid` high. A single interrupt line is raised when the pending flag and the enable bit are both set.

Top module: `uart_regfront`

## Requirements
- R1: The register is selected by byte-address bits [3:2]: index 0 is receive data, 1 is transmit data, 2 is status, 3 is control. `bus_rdata` and a one-cycle `bus_rvalid` appear in the cycle after `bus_rd`. Reading the transmit register returns the last word written to it.
- R2: The status byte is laid out as follows. Bit 0 is set when the queue is non-empty. Bit 1 is set when the queue holds 8 bytes. Bit 2 is set when the transmit buffer is empty, and bit 3 when it holds a byte. Bit 4 is the pending flag, bits 5, 6 and 7 mirror `ser_overrun`, `ser_frame_err` and `ser_parity_err`, and bits 31:8 read as zero. After reset the status reads 0x04.
- R3: The receive queue holds up to 8 bytes in arrival order. `rx_ready` is high exactly while fewer than 8 are held. A byte offered while 8 are held is discarded.
- R4: A read of the receive register returns the oldest byte and removes it. A read while the queue is empty leaves it empty.
- R5: A control write stores the written word, which later reads back unchanged. If bit 1 of the written word is set, the receive queue is emptied.
- R6: A transmit write loads its low byte into the holding buffer. A write while the buffer is full replaces the held byte. The byte is presented on `tx_valid`/`tx_data` and stays stable until `tx_ready` accepts it, which empties the buffer.
- R7: A control write with bit 0 set discards any held transmit byte.
- R8: The pending flag (status bit 4) is set while the queue is non-empty, and it is also set by any transmit write. A status read clears it, unless the queue is still non-empty after that cycle.
- R9: `irq` is high exactly when the pending flag and control bit 4 are both set.
- R10: A write to the status register changes no state. It pulses `bus_wr_err` for one cycle in the following cycle.
- R11: After reset, `irq` and `tx_valid` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bus_wr_err | output | 1 | One-cycle pulse after a status write |
| rx_valid | input | 1 | Received byte offered by the serializer |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue has room |
| tx_valid | output | 1 | Transmit byte held and offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| ser_overrun | input | 1 | Overrun indication from the serializer |
| ser_frame_err | input | 1 | Frame error indication from the serializer |
| ser_parity_err | input | 1 | Parity error indication from the serializer |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the queue never counts past eight;
- a byte offered to a full queue leaves the count unchanged;
- a pop lowers the count by one, and a receive reset empties the queue;
- a stalled transmit byte holds steady, and a transmit reset drops it;
- the pending flag is set whenever data waits and after every transmit write;
- a status write raises the error pulse and leaves the control register alone.

Only the bench scenarios can show the rest:
- arrival order through the queue, and that the dropped ninth byte never comes out;
- that a held byte is delivered exactly once;
- the exact status encodings as the queue and buffer fill and drain;
- the sticky pending flag and its clear-on-read;
- how the interrupt follows the enable bit.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  typedef enum logic [1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } urf_reg_e;

  // status byte positions
  localparam int ST_RX_AVAIL = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;
  localparam int ST_PENDING  = 4;
  localparam int ST_OVERRUN  = 5;
  localparam int ST_FRAME    = 6;
  localparam int ST_PARITY   = 7;

  // control word positions
  localparam int CT_TX_FLUSH = 0;
  localparam int CT_RX_FLUSH = 1;
  localparam int CT_IRQ_EN   = 4;

  localparam int STAT_W = 8;

endpackage

// File: rtl/urf_rx_queue.sv
module urf_rx_queue #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);

  localparam int IW = CNT_W + 1;

  logic [BYTE_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wptr;
  logic [IW-1:0]     wp_ext, cnt_ext, rd_ext;
  logic [PTR_W-1:0]  rd_idx;
  logic              accept, take;

  assign in_ready = (count < CNT_W'(DEPTH));
  assign accept   = in_valid && in_ready && !flush;
  assign take     = pop && (count != '0) && !flush;

  // oldest entry sits count places behind the write pointer
  always_comb begin
    wp_ext  = IW'(wptr);
    cnt_ext = IW'(count);
    if (wp_ext >= cnt_ext) rd_ext = wp_ext - cnt_ext;
    else                   rd_ext = wp_ext + IW'(DEPTH) - cnt_ext;
    rd_idx = PTR_W'(rd_ext);
  end

  assign head = slot[rd_idx];

  always_comb begin
    if (flush) count_next = '0;
    else       count_next = count + CNT_W'(accept) - CNT_W'(take);
  end

  always_ff @(posedge clk) begin
    if (accept) slot[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      count <= '0;
    end else begin
      count <= count_next;
      if (flush)
        wptr <= '0;
      else if (accept)
        wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    end
  end

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && in_valid && !pop && !flush)
      |=> count == CNT_W'(DEPTH));

  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count != '0 && !in_valid && !flush)
      |=> count == $past(count) - 1'b1);

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && in_ready));

endmodule

// File: rtl/urf_tx_hold.sv
module urf_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);

  logic              held_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      byte_q <= '0;
    end else if (flush) begin
      held_q <= 1'b0;
    end else if (load) begin
      held_q <= 1'b1;
      byte_q <= load_data;
    end else if (held_q && out_ready) begin
      held_q <= 1'b0;
    end
  end

  assign out_valid = held_q;
  assign out_data  = byte_q;

  // R6
  tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush && !load)
      |=> (out_valid && $stable(out_data)));

  // R7
  tx_flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

endmodule

// File: rtl/urf_status.sv
module urf_status
  import uart_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  rx_count_next,
  input  logic              tx_held,
  input  logic              wr_tx,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ser_overrun,
  input  logic              ser_frame_err,
  input  logic              ser_parity_err,
  output logic [STAT_W-1:0] stat_byte,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pending,
  output logic              irq
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      pend_q <= (pend_q && !rd_stat) || wr_tx || (rx_count_next != '0);
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  always_comb begin
    stat_byte              = '0;
    stat_byte[ST_RX_AVAIL] = (rx_count != '0);
    stat_byte[ST_RX_FULL]  = (rx_count == CNT_W'(DEPTH));
    stat_byte[ST_TX_EMPTY] = !tx_held;
    stat_byte[ST_TX_FULL]  = tx_held;
    stat_byte[ST_PENDING]  = pend_q;
    stat_byte[ST_OVERRUN]  = ser_overrun;
    stat_byte[ST_FRAME]    = ser_frame_err;
    stat_byte[ST_PARITY]   = ser_parity_err;
  end

  assign pending = pend_q;
  assign irq     = pend_q && ctrl_q[CT_IRQ_EN];

  // R8
  pend_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != '0) |-> pend_q);

  // R8
  pend_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> pend_q);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_wr_err,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              ser_overrun,
  input  logic              ser_frame_err,
  input  logic              ser_parity_err,
  output logic              irq
);

  urf_reg_e          sel;
  logic              wr_tx, wr_ctrl, wr_stat, rd_rx, rd_stat;
  logic              rx_flush, tx_flush;
  logic [BYTE_W-1:0] rx_head;
  logic [CNT_W-1:0]  rx_count, rx_count_next;
  logic [STAT_W-1:0] stat_byte;
  logic [DATA_W-1:0] ctrl_q, tx_word_q, rd_mux;
  logic              pending;

  assign sel      = urf_reg_e'(bus_addr[3:2]);
  assign wr_tx    = bus_wr && (sel == REG_TXD);
  assign wr_ctrl  = bus_wr && (sel == REG_CTRL);
  assign wr_stat  = bus_wr && (sel == REG_STAT);
  assign rd_rx    = bus_rd && (sel == REG_RXD);
  assign rd_stat  = bus_rd && (sel == REG_STAT);
  assign rx_flush = wr_ctrl && bus_wdata[CT_RX_FLUSH];
  assign tx_flush = wr_ctrl && bus_wdata[CT_TX_FLUSH];

  urf_rx_queue #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (rx_flush),
    .in_valid   (rx_valid),
    .in_data    (rx_data),
    .in_ready   (rx_ready),
    .pop        (rd_rx),
    .head       (rx_head),
    .count      (rx_count),
    .count_next (rx_count_next)
  );

  urf_tx_hold #(.BYTE_W(BYTE_W)) u_txh (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .load      (wr_tx),
    .load_data (bus_wdata[BYTE_W-1:0]),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready)
  );

  urf_status #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_count       (rx_count),
    .rx_count_next  (rx_count_next),
    .tx_held        (tx_valid),
    .wr_tx          (wr_tx),
    .wr_ctrl        (wr_ctrl),
    .rd_stat        (rd_stat),
    .wdata          (bus_wdata),
    .ser_overrun    (ser_overrun),
    .ser_frame_err  (ser_frame_err),
    .ser_parity_err (ser_parity_err),
    .stat_byte      (stat_byte),
    .ctrl_q         (ctrl_q),
    .pending        (pending),
    .irq            (irq)
  );

  always_comb begin
    unique case (sel)
      REG_RXD:  rd_mux = DATA_W'(rx_head);
      REG_TXD:  rd_mux = tx_word_q;
      REG_STAT: rd_mux = DATA_W'(stat_byte);
      default:  rd_mux = ctrl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_wr_err <= 1'b0;
      tx_word_q  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_wr_err <= wr_stat;
      if (bus_rd) bus_rdata <= rd_mux;
      if (wr_tx)  tx_word_q <= bus_wdata;
    end
  end

  // R10
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (bus_wr_err && $stable(ctrl_q) && $stable(rx_count)));

  // R1
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R9
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pending);

endmodule

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_wr_err;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        ser_overrun = 1'b0, ser_frame_err = 1'b0, ser_parity_err = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int tx_seen = 0;
  logic [7:0] rx_exp[$];
  logic [7:0] tx_exp[$];
  logic [31:0] rd;

  localparam logic [3:0] A_RX = 4'h0, A_TX = 4'h4, A_ST = 4'h8, A_CT = 4'hC;

  always #2 clk = ~clk;

  uart_regfront u_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_wr_err(bus_wr_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ser_overrun(ser_overrun), .ser_frame_err(ser_frame_err),
    .ser_parity_err(ser_parity_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R1 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  // driver: offer a byte, record it when it should be kept
  task automatic send_rx(input logic [7:0] b, input bit keep);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (keep) rx_exp.push_back(b);
  endtask

  // monitor side of the receive scoreboard
  task automatic take_rx();
    logic [31:0] d;
    logic [7:0]  e;
    rdreg(A_RX, d);
    if (rx_exp.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL R4 unexpected byte actual=0x%0h expected=none", d);
    end else begin
      e = rx_exp.pop_front();
      chk("R4 R3 rx order", d, 32'(e));
    end
  endtask

  task automatic send_tx(input logic [7:0] b, input bit keep);
    wr(A_TX, 32'(b));
    if (keep) tx_exp.push_back(b);
  endtask

  // monitor of the transmit stream
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      tx_seen++;
      if (tx_exp.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R6 R7 unexpected tx actual=0x%0h expected=none", tx_data);
      end else begin
        chk("R6 tx byte", 32'(tx_data), 32'(tx_exp.pop_front()));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R11 irq", 32'(irq), 32'd0);
    chk("R11 rx_ready", 32'(rx_ready), 32'd1);
    chk("R11 tx_valid", 32'(tx_valid), 32'd0);
    rdreg(A_ST, rd); chk("R2 reset status", rd, 32'h04);

    // a few bytes through the queue
    send_rx(8'h11, 1); send_rx(8'h22, 1); send_rx(8'h33, 1);
    rdreg(A_ST, rd); chk("R2 R8 status with data", rd, 32'h15);
    take_rx(); take_rx(); take_rx();
    rdreg(A_ST, rd); chk("R8 sticky pending", rd, 32'h14);
    rdreg(A_ST, rd); chk("R8 cleared by read", rd, 32'h04);

    // fill, overflow
    for (int i = 0; i < 8; i++) send_rx(8'h40 + 8'(i), 1);
    chk("R3 rx_ready full", 32'(rx_ready), 32'd0);
    rdreg(A_ST, rd); chk("R2 R8 full status", rd, 32'h17);
    send_rx(8'hEE, 0);
    for (int i = 0; i < 8; i++) take_rx();
    chk("R3 dropped byte absent", 32'(rx_exp.size()), 32'd0);
    chk("R3 rx_ready again", 32'(rx_ready), 32'd1);
    rdreg(A_ST, rd); chk("R8 after drain", rd, 32'h14);

    // interrupt enable
    wr(A_CT, 32'h10);
    chk("R9 irq no pending", 32'(irq), 32'd0);
    send_rx(8'h77, 1);
    chk("R9 irq on data", 32'(irq), 32'd1);
    rdreg(A_CT, rd); chk("R5 ctrl readback", rd, 32'h10);
    rdreg(A_ST, rd); chk("R8 read keeps pending", rd, 32'h15);
    chk("R8 irq held while data", 32'(irq), 32'd1);
    take_rx();
    rdreg(A_ST, rd); chk("R8 status", rd, 32'h14);
    chk("R9 irq cleared", 32'(irq), 32'd0);

    // empty read
    rdreg(A_RX, rd);
    rdreg(A_ST, rd); chk("R4 empty read stays empty", rd, 32'h04);

    // receive flush
    send_rx(8'h81, 0); send_rx(8'h82, 0);
    wr(A_CT, 32'h12);
    rdreg(A_ST, rd); chk("R5 rx flush", rd, 32'h14);
    wr(A_CT, 32'h10);
    rdreg(A_ST, rd); chk("R5 after flush", rd, 32'h04);
    send_rx(8'h90, 1); take_rx();
    rdreg(A_ST, rd);

    // transmit with back-pressure
    tx_ready = 1'b0;
    send_tx(8'hA5, 1);
    chk("R6 tx_valid", 32'(tx_valid), 32'd1);
    chk("R9 R8 irq on tx write", 32'(irq), 32'd1);
    rdreg(A_ST, rd); chk("R2 tx full status", rd, 32'h18);
    rdreg(A_TX, rd); chk("R1 tx readback", rd, 32'hA5);
    chk("R6 held data", 32'(tx_data), 32'hA5);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6 emptied", 32'(tx_valid), 32'd0);
    rdreg(A_ST, rd); chk("R2 tx empty", rd, 32'h04);
    // replace while full
    send_tx(8'h01, 0);
    send_tx(8'h5A, 1);
    tx_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 tx count", 32'(tx_seen), 32'd2);
    rdreg(A_ST, rd); chk("R8 pending from tx", rd, 32'h14);

    // transmit flush
    tx_ready = 1'b0;
    send_tx(8'h3C, 0);
    wr(A_CT, 32'h11);
    chk("R7 flushed", 32'(tx_valid), 32'd0);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    tx_ready = 1'b0;
    chk("R7 nothing sent", 32'(tx_seen), 32'd2);
    rdreg(A_ST, rd); chk("R7 status", rd, 32'h14);

    // status write ignored
    wr(A_ST, 32'hFF);
    chk("R10 err pulse", 32'(bus_wr_err), 32'd1);
    @(negedge clk);
    chk("R10 err one cycle", 32'(bus_wr_err), 32'd0);
    rdreg(A_CT, rd); chk("R10 ctrl unchanged", rd, 32'h11);
    rdreg(A_ST, rd); chk("R10 status unchanged", rd, 32'h04);

    // serializer error bits
    ser_frame_err = 1'b1; ser_parity_err = 1'b1;
    rdreg(A_ST, rd); chk("R2 error bits", rd, 32'hC4);
    ser_frame_err = 1'b0; ser_parity_err = 1'b0; ser_overrun = 1'b1;
    rdreg(A_ST, rd); chk("R2 overrun bit", rd, 32'h24);

    chk("R6 tx queue drained", 32'(tx_exp.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule